// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

An eight-stage register that is filled all at once from a parallel word and then emptied one bit at a time through its last stage. The last stage is presented on two pins: its true value and its inverse. While the load control is low, every stage copies its parallel input on every system clock, whatever the other inputs are doing. While the load control is high, the register is in shift mode. A serial input feeds the first stage, and each shift moves the contents one position toward the last stage.

The shift clock and the hold (inhibit) input arrive as ordinary signals. Both are sampled in the fast system-clock domain. They are interchangeable: a shift fires when their logical OR rises between two consecutive system cycles. Holding either one high therefore freezes the register. Raising the hold input while the shift clock is low also produces a shift, so hold should only be raised while the shift clock is high.

Top module: `piso_shift8`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0 and clears the stored previous clock sample. After reset, `ser_o` is 0 and `ser_n_o` is 1.
- R2: While `load_n_i` is 0, every system cycle stage k takes `par_i[k]`. Bit 0 is the first stage and bit STAGES-1 is the last stage. After such a cycle `ser_o` equals `par_i[STAGES-1]`.
- R3: While `load_n_i` is 0, `sclk_i`, `hold_i` and `ser_i` have no effect on the stages.
- R4: With `load_n_i` at 1 and `hold_i` at 0, a 0-to-1 change of `sclk_i` between consecutive system cycles causes exactly one shift. Staying high causes no further shift.
- R5: With `load_n_i` at 1 and `sclk_i` at 0, a 0-to-1 change of `hold_i` also causes exactly one shift.
- R6: While `hold_i` stays 1, pulses on `sclk_i` cause no shift.
- R7: On a shift, stage k+1 takes the old stage k and stage 0 takes `ser_i`. After n shifts from a load, `ser_o` shows loaded bit STAGES-1-n, or a serial bit once n reaches STAGES.
- R8: `ser_n_o` is always the inverse of `ser_o`.
- R9: A rising edge of the OR that occurs while `load_n_i` is 0 is discarded. Releasing the load while the shift clock is already high causes no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | External shift clock, sampled |
| hold_i | input | 1 | Hold/inhibit input, interchangeable with sclk_i |
| load_n_i | input | 1 | 0 = parallel load, 1 = shift mode |
| par_i | input | STAGES | Parallel data, bit 0 = first stage |
| ser_i | input | 1 | Serial data into the first stage |
| ser_o | output | 1 | Last stage, true |
| ser_n_o | output | 1 | Last stage, inverted |

## Verification
The assertions check on every cycle that:
- a load captures the parallel word;
- a shift pulse moves the stages by one position with the serial bit entering first;
- a cycle without a load or a pulse leaves the stages unchanged;
- a pulse never lasts two cycles;
- a held-high hold input blocks pulses.

Only the bench's scenarios can show the end-to-end facts, by comparing the outputs each cycle against a queue-based reference model:
- a rising hold while the shift clock is low shifts;
- an edge seen during a load is lost after release;
- the serial bits reach the output after a full drain.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } piso_mode_e;

  // Load wins over a pending shift pulse in the same cycle.
  function automatic piso_mode_e pick_mode(input logic load_n, input logic pulse);
    if (!load_n)    return MODE_LOAD;
    else if (pulse) return MODE_SHIFT;
    else            return MODE_HOLD;
  endfunction
endpackage

// File: rtl/piso_edge_det.sv
module piso_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic hold_i,
  input  logic load_n_i,
  output logic shift_pulse_o
);
  logic gate_now;
  logic gate_prev_q;
  logic gate_rise;

  assign gate_now  = sclk_i | hold_i;
  assign gate_rise = gate_now & ~gate_prev_q;
  // A rise seen during a load is consumed here and never replayed.
  assign shift_pulse_o = gate_rise & load_n_i;

  always_ff @(posedge clk) begin
    if (rst) gate_prev_q <= 1'b0;
    else     gate_prev_q <= gate_now;
  end

  // R4: a pulse is a single cycle wide
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    shift_pulse_o |=> !shift_pulse_o);

  // R6: hold high on two consecutive sampled cycles blocks any pulse
  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(hold_i) && hold_i) |-> !shift_pulse_o);
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
  import piso_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  piso_mode_e        mode_i,
  input  logic [STAGES-1:0] par_i,
  input  logic              ser_i,
  output logic [STAGES-1:0] stages_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;

  function automatic logic [STAGES-1:0] advance(input logic [STAGES-1:0] cur,
                                                input logic bit_in);
    logic [STAGES-1:0] nxt;
    nxt[0] = bit_in;
    for (int k = 1; k <= LAST; k++) nxt[k] = cur[k-1];
    return nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      case (mode_i)
        MODE_LOAD:  stage_q <= par_i;
        MODE_SHIFT: stage_q <= advance(stage_q, ser_i);
        default:    stage_q <= stage_q;
      endcase
    end
  end

  assign stages_o = stage_q;

  // R2: a load cycle captures the parallel word
  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_LOAD) |=> (stage_q == $past(par_i)));

  // R7: a shift moves each stage up one place, serial bit entering stage 0
  a_r7_shift_move: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_SHIFT) |=>
      (stage_q[LAST:1] == $past(stage_q[LAST-1:0]) && stage_q[0] == $past(ser_i)));

  // R3: no load and no shift leaves every stage unchanged
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_HOLD) |=> $stable(stage_q));
endmodule

// File: rtl/piso_shift8.sv
module piso_shift8
  import piso_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              hold_i,
  input  logic              load_n_i,
  input  logic [STAGES-1:0] par_i,
  input  logic              ser_i,
  output logic              ser_o,
  output logic              ser_n_o
);
  localparam int LAST = STAGES - 1;

  logic              shift_pulse;
  piso_mode_e        mode;
  logic [STAGES-1:0] stages;

  piso_edge_det u_edge (
    .clk           (clk),
    .rst           (rst),
    .sclk_i        (sclk_i),
    .hold_i        (hold_i),
    .load_n_i      (load_n_i),
    .shift_pulse_o (shift_pulse)
  );

  assign mode = pick_mode(load_n_i, shift_pulse);

  piso_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .par_i    (par_i),
    .ser_i    (ser_i),
    .stages_o (stages)
  );

  assign ser_o   = stages[LAST];
  assign ser_n_o = ~stages[LAST];

  // R9: no shift pulse is ever issued during a load cycle
  a_r9_load_priority: assert property (@(posedge clk) disable iff (rst)
    !load_n_i |-> (mode == MODE_LOAD));

  // R1: the cycle after reset shows a cleared last stage
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ser_o == 1'b0));
endmodule

// File: tb/piso_shift8_tb_top.sv
`timescale 1ns/1ps
module piso_shift8_tb_top;
  localparam int STAGES = 8;

  logic clk = 1'b0;
  logic rst, sclk_i, hold_i, load_n_i, ser_i;
  logic [STAGES-1:0] par_i;
  logic ser_o, ser_n_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit live = 1'b0;

  always #2 clk = ~clk;

  piso_shift8 #(.STAGES(STAGES)) dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .hold_i(hold_i),
    .load_n_i(load_n_i), .par_i(par_i), .ser_i(ser_i),
    .ser_o(ser_o), .ser_n_o(ser_n_o)
  );

  // Behavioural reference: queue front is the output end.
  bit model_q[$];
  bit prev_or = 1'b0;

  always @(posedge clk) begin
    bit now_or;
    if (rst) begin
      model_q = {};
      for (int i = 0; i < STAGES; i++) model_q.push_back(1'b0);
      prev_or = 1'b0;
    end else begin
      now_or = sclk_i | hold_i;
      if (!load_n_i) begin
        model_q = {};
        for (int i = STAGES - 1; i >= 0; i--) model_q.push_back(par_i[i]);
      end else if (now_or && !prev_or) begin
        void'(model_q.pop_front());
        model_q.push_back(ser_i);
      end
      prev_or = now_or;
    end
  end

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Every cycle: both outputs against the model (R8 for the inverse).
  always @(negedge clk) begin
    if (live && !rst) begin
      check(ser_o, model_q[0], cur_req);
      check(ser_n_o, ~model_q[0], "R8");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_last(input logic e, input string req);
    check(ser_o, e, req);
    check(ser_n_o, ~e, req);
  endtask

  task automatic pulse_sclk();
    sclk_i = 1'b1; cyc(2);
    sclk_i = 1'b0; cyc(2);
  endtask

  task automatic do_load(input logic [STAGES-1:0] w);
    load_n_i = 1'b0; par_i = w; cyc(2);
    load_n_i = 1'b1; cyc(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; sclk_i = 0; hold_i = 0; load_n_i = 1; ser_i = 0; par_i = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    live = 1'b1;
    // R1
    expect_last(1'b0, "R1");

    // R2: load 0xA5, last stage shows bit 7 = 1
    cur_req = "R2";
    do_load(8'hA5);
    expect_last(1'b1, "R2");

    // R3: inputs toggle during a load, contents follow par_i only
    cur_req = "R3";
    load_n_i = 1'b0; par_i = 8'h3C;
    for (int i = 0; i < 6; i++) begin
      sclk_i = i[0]; hold_i = i[1]; ser_i = ~i[0];
      cyc(1);
    end
    expect_last(1'b0, "R3");
    sclk_i = 0; hold_i = 0; ser_i = 1'b1; cyc(1);
    load_n_i = 1'b1; cyc(2);
    expect_last(1'b0, "R3");

    // R4/R7: five clock pulses, serial=1; stages 0011_1100
    cur_req = "R4";
    pulse_sclk();
    expect_last(1'b0, "R4");
    sclk_i = 1'b1; cyc(4);  // staying high gives one shift only
    sclk_i = 1'b0; cyc(2);
    expect_last(1'b1, "R4");
    cur_req = "R7";
    for (int i = 0; i < 3; i++) pulse_sclk();
    expect_last(1'b1, "R7");

    // R5: hold rises while sclk low -> shift 6 shows bit 1 = 0
    cur_req = "R5";
    hold_i = 1'b1; cyc(2);
    expect_last(1'b0, "R5");

    // R6: sclk pulses while hold high do nothing
    cur_req = "R6";
    for (int i = 0; i < 3; i++) pulse_sclk();
    expect_last(1'b0, "R6");
    hold_i = 1'b0; cyc(2);
    expect_last(1'b0, "R6");

    // R7: shift 7 shows bit 0 = 0, shift 8 shows the serial 1
    cur_req = "R7";
    pulse_sclk();
    expect_last(1'b0, "R7");
    pulse_sclk();
    expect_last(1'b1, "R7");

    // R9: sclk rises during load, release with sclk high -> no shift
    cur_req = "R9";
    load_n_i = 1'b0; par_i = 8'h80; cyc(1);
    sclk_i = 1'b1; cyc(2);
    load_n_i = 1'b1; cyc(3);
    expect_last(1'b1, "R9");
    sclk_i = 1'b0; cyc(2);
    expect_last(1'b1, "R9");

    // R7: full drain of zeros, serial ones arrive after STAGES shifts
    cur_req = "R7";
    ser_i = 1'b1;
    do_load(8'h00);
    for (int i = 0; i < STAGES - 1; i++) pulse_sclk();
    expect_last(1'b0, "R7");
    pulse_sclk();
    expect_last(1'b1, "R7");

    // R1: reset in mid-run clears the stages
    cur_req = "R1";
    live = 1'b0;
    rst = 1'b1; cyc(2);
    rst = 1'b0; cyc(1);
    live = 1'b1;
    expect_last(1'b0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule